// File: doc/BRIEF.md
# UART Flow Control and Driver Enable

This block sits between a UART transmit/receive core and its pins and decides when the core may begin a new character, what level the shared request/driver-enable pin carries, and when a change on the clear-to-send input deserves an interrupt. The active-low clear-to-send pin passes through a synchronizer. When clear-to-send gating is on, the block grants a new transmission only while that synchronized input is low. A character already on the line always runs to its last stop bit. Data that arrives while the input is high waits until it goes low again.

The same output pin serves two uses. In ready-to-receive mode it is driven low while the receive buffer can accept a character. In driver-enable mode it marks the whole time a frame is on the line, for an external half-duplex transceiver, and a polarity bit chooses the active level. Configuration arrives through a write strobe. The mode and polarity bits can only change while the peripheral enable is low. The interrupt-enable bit can be written at any time.

Top module: `uart_flow_ctl`

## Requirements
- R1: With clear-to-send gating on (cfg bit 0 = 1), `tx_start_ok` is 1 exactly when `tx_pending` is 1, `tx_busy` is 0 and the synchronized `ncts_pin` is 0.
- R2: `tx_start_ok` is 0 whenever `tx_busy` is 1. A rise of `ncts_pin` during a frame leaves the driver-enable output asserted for as long as `tx_busy` stays 1.
- R3: A pending transmission held back by a high `ncts_pin` is granted once `ncts_pin` returns low, with no new write of data.
- R4: With gating off (cfg bit 0 = 0), `tx_start_ok` equals `tx_pending & ~tx_busy` whatever the level of `ncts_pin`.
- R5: With driver-enable mode off (cfg bit 2 = 0) and ready-to-receive mode on (cfg bit 1 = 1), `rts_de_pin` is 0 exactly when `rx_space` is 1.
- R6: With driver-enable mode on (cfg bit 2 = 1), `rts_de_pin` equals `tx_busy` when cfg bit 3 = 0 (active high) and `~tx_busy` when cfg bit 3 = 1 (active low). This holds regardless of cfg bit 1.
- R7: With cfg bits 1 and 2 both 0, `rts_de_pin` is 1. After reset every cfg bit is 0, `cts_flag` and `irq` are 0, and the synchronizer holds the deasserted level 1.
- R8: Each rising or falling edge of the synchronized `ncts_pin` sets `cts_flag` one cycle after the synchronizer output changes. The flag stays set until a `cts_clr` pulse clears it. If a set and a clear fall in the same cycle, the set wins.
- R9: `irq` is 1 exactly when `cts_flag` is 1 and the interrupt-enable bit (cfg bit 4) is 1.
- R10: A config write while `enable` is 1 leaves cfg bits 0 to 3 unchanged but still updates cfg bit 4.
- R11: A change of `ncts_pin` reaches `tx_start_ok` after exactly SYNC_STAGES rising clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Peripheral enable; locks cfg bits 0 to 3 while 1 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Bit 0 gating, 1 ready-to-receive, 2 driver-enable, 3 DE active low, 4 interrupt enable |
| cts_clr | input | 1 | Write-one-to-clear strobe for the change flag |
| ncts_pin | input | 1 | Active-low clear-to-send pin, asynchronous |
| tx_pending | input | 1 | Core has a character waiting to send |
| tx_busy | input | 1 | Core is sending a frame, from start bit to end of stop bits |
| rx_space | input | 1 | Receive buffer can accept a character |
| tx_start_ok | output | 1 | Core may start the pending character |
| rts_de_pin | output | 1 | Shared ready-to-receive / driver-enable pin |
| cts_flag | output | 1 | Sticky clear-to-send change flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a two-stage synchronizer, set-wins flag priority and an idle pin level of 1. The two-stage synchronizer makes the latency small enough to check cycle by cycle. The bench confirms that the grant is still old one edge after a pin change and new on the second edge, and that the flag appears one edge after that. Because the configuration is only five bits wide, the bench sweeps every pin-mode combination against every level of the busy and buffer-space inputs. It also sweeps every gating combination of mode, pin level, pending and busy.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
   // Field order sets the write-data bit positions: cts_mode is bit 0.
   typedef struct packed {
      logic cts_irq_en;
      logic de_active_low;
      logic de_mode;
      logic rts_mode;
      logic cts_mode;
   } fc_cfg_t;

   localparam int CFG_W = $bits(fc_cfg_t);
endpackage

// File: rtl/uart_fc_cfg.sv
module uart_fc_cfg
   import uart_fc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   output fc_cfg_t          cfg_q
);
   fc_cfg_t wr;
   assign wr = fc_cfg_t'(cfg_wdata);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (cfg_we) begin
         cfg_q.cts_irq_en <= wr.cts_irq_en;
         if (!enable) begin
            cfg_q.de_active_low <= wr.de_active_low;
            cfg_q.de_mode       <= wr.de_mode;
            cfg_q.rts_mode      <= wr.rts_mode;
            cfg_q.cts_mode      <= wr.cts_mode;
         end
      end
   end

   a_r10_locked_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (enable || !cfg_we) |=> $stable({cfg_q.de_active_low, cfg_q.de_mode,
                                       cfg_q.rts_mode, cfg_q.cts_mode}));
endmodule

// File: rtl/uart_fc_sync.sv
module uart_fc_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("uart_fc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[gi] <= RST_VAL;
            else if (gi == 0) chain[gi] <= d_async;
            else chain[gi] <= chain[(gi == 0) ? 0 : gi-1];
         end
      end
   endgenerate

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/uart_fc_cts_detect.sv
module uart_fc_cts_detect #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cts_sync,
   input  logic clr,
   output logic flag
);
   logic prev_q;
   logic change;
   logic flag_d;

   assign change = cts_sync ^ prev_q;

   generate
      if (SET_WINS) begin : g_set_priority
         assign flag_d = change | (flag & ~clr);
      end else begin : g_clr_priority
         assign flag_d = ~clr & (flag | change);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b1;
         flag   <= 1'b0;
      end else begin
         prev_q <= cts_sync;
         flag   <= flag_d;
      end
   end

   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);
   a_r8_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (SET_WINS && $past(cts_sync) != cts_sync) |=> ##1 flag);
endmodule

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl
   import uart_fc_pkg::*;
#(
   parameter int   SYNC_STAGES    = 2,
   parameter bit   SET_WINS       = 1'b1,
   parameter logic IDLE_PIN_LEVEL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             cts_clr,
   input  logic             ncts_pin,
   input  logic             tx_pending,
   input  logic             tx_busy,
   input  logic             rx_space,
   output logic             tx_start_ok,
   output logic             rts_de_pin,
   output logic             cts_flag,
   output logic             irq
);
   fc_cfg_t cfg;
   logic    ncts_s;

   uart_fc_cfg i_cfg (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg)
   );

   uart_fc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
      .clk(clk), .rst_n(rst_n), .d_async(ncts_pin), .q_sync(ncts_s)
   );

   uart_fc_cts_detect #(.SET_WINS(SET_WINS)) i_detect (
      .clk(clk), .rst_n(rst_n), .cts_sync(ncts_s), .clr(cts_clr), .flag(cts_flag)
   );

   // Gating only ever blocks a start; a frame in flight is never cut.
   logic cts_allows;
   assign cts_allows  = !cfg.cts_mode || !ncts_s;
   assign tx_start_ok = tx_pending && !tx_busy && cts_allows;

   always_comb begin
      if (cfg.de_mode)       rts_de_pin = tx_busy ^ cfg.de_active_low;
      else if (cfg.rts_mode) rts_de_pin = !rx_space;
      else                   rts_de_pin = IDLE_PIN_LEVEL;
   end

   assign irq = cts_flag && cfg.cts_irq_en;

   a_r2_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      tx_busy |-> !tx_start_ok);
   a_r1_blocked_when_high: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.cts_mode && ncts_s) |-> !tx_start_ok);
   a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> cts_flag);
   a_r6_de_follows_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.de_mode && tx_busy) |-> (rts_de_pin != cfg.de_active_low));
endmodule

// File: tb/test_uart_flow_ctl.sv
`timescale 1ns/1ps
module test_uart_flow_ctl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0, cfg_we = 1'b0, cts_clr = 1'b0;
   logic [4:0] cfg_wdata = '0;
   logic ncts_pin = 1'b1, tx_pending = 1'b0, tx_busy = 1'b0, rx_space = 1'b0;
   logic tx_start_ok, rts_de_pin, cts_flag, irq;
   int tests = 0, fails = 0;

   always #10 clk = ~clk;

   uart_flow_ctl i_uart_flow_ctl (
      .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
      .cfg_wdata(cfg_wdata), .cts_clr(cts_clr), .ncts_pin(ncts_pin),
      .tx_pending(tx_pending), .tx_busy(tx_busy), .rx_space(rx_space),
      .tx_start_ok(tx_start_ok), .rts_de_pin(rts_de_pin),
      .cts_flag(cts_flag), .irq(irq)
   );

   task automatic check(input logic got, input logic exp, input string req);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0b expected %0b", req, got, exp);
      end
   endtask

   // cfg word: {irq_en, de_active_low, de_mode, rts_mode, cts_mode}
   task automatic write_cfg(input logic [4:0] w);
      @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic clear_flag();
      @(negedge clk); cts_clr = 1'b1;
      @(negedge clk); cts_clr = 1'b0;
   endtask

   initial begin
      #(200000 * 20);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R7 reset state
      check(rts_de_pin, 1'b1, "R7 pin idle after reset");
      check(cts_flag, 1'b0, "R7 flag clear after reset");
      check(irq, 1'b0, "R7 irq clear after reset");
      tx_pending = 1'b1; #1;
      check(tx_start_ok, 1'b1, "R7 gating off after reset");
      tx_pending = 1'b0;

      // R5 R6 R7 sweep over pin modes
      for (int m = 0; m < 8; m++) begin
         write_cfg({1'b0, m[2], m[1], m[0], 1'b0});
         for (int v = 0; v < 4; v++) begin
            tx_busy = v[0]; rx_space = v[1]; #1;
            if (m[1])      check(rts_de_pin, v[0] ^ m[2], "R6 DE level");
            else if (m[0]) check(rts_de_pin, ~v[1], "R5 ready level");
            else           check(rts_de_pin, 1'b1, "R7 idle level");
            @(negedge clk);
         end
      end
      tx_busy = 1'b0; rx_space = 1'b0;

      // R1 R4 sweep over gating
      for (int c = 0; c < 2; c++) begin
         write_cfg({4'b0, c[0]});
         for (int v = 0; v < 8; v++) begin
            @(negedge clk); ncts_pin = v[0];
            repeat (3) @(negedge clk);
            tx_pending = v[1]; tx_busy = v[2]; #1;
            if (c[0]) check(tx_start_ok, v[1] & ~v[2] & ~v[0], "R1 gated grant");
            else      check(tx_start_ok, v[1] & ~v[2], "R4 ungated grant");
         end
      end
      tx_pending = 1'b0; tx_busy = 1'b0;

      // R2 R3 R11: frame continues across nCTS rise, held data resumes
      write_cfg(5'b00101);           // gating + DE active high
      @(negedge clk); ncts_pin = 1'b0;
      repeat (3) @(negedge clk);
      tx_pending = 1'b1; #1;
      check(tx_start_ok, 1'b1, "R1 grant with nCTS low");
      @(negedge clk); tx_busy = 1'b1; tx_pending = 1'b0; ncts_pin = 1'b1;
      repeat (4) begin
         @(negedge clk); #1;
         check(rts_de_pin, 1'b1, "R2 DE held during frame");
         check(tx_start_ok, 1'b0, "R2 no start while busy");
      end
      @(negedge clk); tx_busy = 1'b0; tx_pending = 1'b1; #1;
      check(rts_de_pin, 1'b0, "R6 DE drops when idle");
      check(tx_start_ok, 1'b0, "R3 held while nCTS high");
      ncts_pin = 1'b0;
      @(negedge clk); #1;
      check(tx_start_ok, 1'b0, "R11 not yet after one edge");
      @(negedge clk); #1;
      check(tx_start_ok, 1'b1, "R11 R3 granted after two edges");
      tx_pending = 1'b0;

      // R8 edge timing and stickiness
      repeat (3) @(negedge clk);
      clear_flag(); #1;
      check(cts_flag, 1'b0, "R8 flag cleared");
      ncts_pin = 1'b1;               // at a negedge
      @(negedge clk); @(negedge clk); #1;
      check(cts_flag, 1'b0, "R8 flag not yet set");
      @(negedge clk); #1;
      check(cts_flag, 1'b1, "R8 flag set on rise");
      repeat (5) @(negedge clk); #1;
      check(cts_flag, 1'b1, "R8 flag sticky");
      check(irq, 1'b0, "R9 irq masked");
      clear_flag(); #1;
      check(cts_flag, 1'b0, "R8 clear strobe");
      // falling edge, with clear pulsed in the set cycle
      @(negedge clk); ncts_pin = 1'b0;
      @(negedge clk); @(negedge clk); cts_clr = 1'b1;
      @(negedge clk); cts_clr = 1'b0; #1;
      check(cts_flag, 1'b1, "R8 set wins over clear");

      // R10 locked bits and always-writable irq enable
      clear_flag();
      write_cfg(5'b00010);           // ready mode only
      enable = 1'b1;
      write_cfg(5'b11100);           // try DE active low, ie=1
      rx_space = 1'b1; tx_busy = 1'b0; #1;
      check(rts_de_pin, 1'b0, "R10 mode bits locked");
      rx_space = 1'b0; #1;
      check(rts_de_pin, 1'b1, "R10 ready mode still active");
      @(negedge clk); ncts_pin = 1'b1;
      repeat (3) @(negedge clk); #1;
      check(irq, 1'b1, "R9 R10 irq enabled while locked");
      clear_flag(); #1;
      check(irq, 1'b0, "R9 irq follows flag");
      enable = 1'b0;

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule